// File: doc/BRIEF.md
# I2C Target with Per-Byte Clock Stretching

This block is a 7-bit-address I2C target. It connects to the open-drain SCL and SDA lines and serves a local byte-buffer side. Both lines are sampled on the system clock. The block finds START and STOP conditions in the sampled values. After a START it shifts in the address byte. It acknowledges only its own address, then either receives written bytes or sends bytes supplied by the local side.

After every byte it handles, the target holds SCL low and raises a service request. Such a byte is a matched address, a written byte, or a read byte the controller acknowledged. SCL stays low until the local side answers with a one-cycle done pulse. The local side therefore sets the pace of the transfer.

Written bytes are refused with a negative acknowledge whenever the local side reports that its buffer is full at the moment the byte completes.

Top module: `i2c_stretch_target`

## Requirements
- R1: The first byte after a START carries a 7-bit address in bits 7..1. The target pulls SDA low on the ninth clock only when that address equals OWN_ADDR. For any other address it neither drives SDA nor requests service until the next START or STOP.
- R2: Written bytes are taken most significant bit first, eight bits per byte. Each completed byte appears on wrData together with a one-cycle wrValid pulse.
- R3: An accepted written byte is acknowledged by driving SDA low for the whole ninth clock.
- R4: For a read, the target captures rdData when a service completes and pulses rdLoad in that same step. It sends the captured byte most significant bit first and leaves SDA released during the controller's acknowledge clock.
- R5: When the controller leaves SDA high on the ninth clock of a read byte, the target stops driving data. It raises no further service request or rdLoad until a START or STOP.
- R6: If bufFull is high when a written byte completes, the target leaves SDA high on the ninth clock and does not pulse wrValid.
- R7: The target holds SCL low while svcReq is high. It does so after a matched address, after each written byte, and after each read byte the controller acknowledged. svcReq stays high until svcDone, and SCL is released when svcReq drops. SDA is never driven during this stretch.
- R8: After reset, and after a STOP (SDA rising while SCL is high), both line drivers are off. Clock pulses without a new START then cause no acknowledge and no written byte.
- R9: A START (SDA falling while SCL is high) seen in the middle of a byte drops that byte and restarts address reception.
- R10: Bit 0 of the address byte selects the direction: 1 means the controller reads from the target, 0 means it writes to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low (open-drain enable) |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| wrData | output | DATA_W | Last byte written by the controller |
| wrValid | output | 1 | One-cycle strobe marking a new wrData byte |
| bufFull | input | 1 | Local buffer cannot take another written byte |
| rdData | input | DATA_W | Next byte to send to the controller |
| rdLoad | output | 1 | One-cycle strobe: rdData was captured |
| svcReq | output | 1 | Byte handled, SCL is being held low |
| svcDone | input | 1 | Local side finished servicing, release SCL |

## Verification
Every 7-bit address is tried with the write bit, which separates matching from non-matching decoding. Some of the foreign addresses are followed by a data byte to show the target stays silent. Written bytes include walking ones, which expose any bit-order fault, and arithmetic patterns, which expose shift and count faults. Reads are checked against a computed sequence, with the controller acknowledging all but the last byte, so the point where the target stops driving is visible. A byte written with the buffer full, a repeated START after four bits, and bare clocks after a STOP each cover one refusal or abort path. Every service stretch is timed on the bus line itself.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WRITE, ST_HOLD, ST_ACK, ST_READ, ST_RDACK, ST_SKIP
  } tgtState_e;

  typedef enum logic [1:0] {SDA_REL, SDA_ACK, SDA_DATA} sdaMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic cntInc;
    logic shiftIn;
    logic shiftOut;
    logic loadRd;
  } dpCmd_t;

  // bus events from datapath to control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
  } busEv_t;
endpackage

// File: rtl/i2c_tgt_dp.sv
`timescale 1ns/1ps
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] rdData,
  output busEv_t            ev,
  output logic              byteDone,
  output logic [DATA_W-1:0] shiftByte,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              msbOut
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);
  localparam int SYNC_D = 3; // two sync flops plus one history flop

  logic [SYNC_D-1:0] sclPipe, sdaPipe;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_D-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_D-2:0], sdaIn};
    end
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = sclPipe[SYNC_D-2];
  assign sclOld = sclPipe[SYNC_D-1];
  assign sdaNow = sdaPipe[SYNC_D-2];
  assign sdaOld = sdaPipe[SYNC_D-1];

  always_comb begin
    ev.startDet = sclNow & sclOld & sdaOld & ~sdaNow;
    ev.stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;
    ev.sclRise  = sclNow & ~sclOld;
    ev.sclFall  = ~sclNow & sclOld;
    ev.sdaBit   = sdaNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (cmd.loadRd)        shiftReg <= rdData;
      else if (cmd.shiftIn)  shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
      else if (cmd.shiftOut) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      if (cmd.clrCnt)        bitCnt <= '0;
      else if (cmd.cntInc)   bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign byteDone  = (bitCnt == LAST_CNT);
  assign shiftByte = shiftReg;
  assign addrMatch = (shiftReg[DATA_W-1 -: ADDR_W] == OWN_ADDR);
  assign rwBit     = shiftReg[0];
  assign msbOut    = shiftReg[DATA_W-1];
endmodule

// File: rtl/i2c_tgt_ctl.sv
`timescale 1ns/1ps
module i2c_tgt_ctl
  import i2c_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busEv_t   ev,
  input  logic     byteDone,
  input  logic     addrMatch,
  input  logic     rwBit,
  input  logic     bufFull,
  input  logic     svcDone,
  output dpCmd_t   cmd,
  output logic     sclLow,
  output sdaMode_e sdaMode,
  output logic     svcReq,
  output logic     wrValid,
  output logic     rdLoad
);
  tgtState_e state;
  logic isAddr, rwReg, ackNext, hostAck;

  always_comb begin
    cmd = '0;
    if (ev.startDet) begin
      cmd.clrCnt = 1'b1;
    end else if (!ev.stopDet) begin
      unique case (state)
        ST_ADDR, ST_WRITE: begin
          cmd.shiftIn = ev.sclRise;
          cmd.cntInc  = ev.sclRise;
        end
        ST_READ: begin
          cmd.cntInc   = ev.sclRise;
          cmd.shiftOut = ev.sclFall & ~byteDone;
        end
        ST_HOLD: begin
          cmd.loadRd = svcDone & rwReg;
          cmd.clrCnt = svcDone & rwReg & ~isAddr;
        end
        ST_ACK:  cmd.clrCnt = ev.sclFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sclLow  <= 1'b0;
      sdaMode <= SDA_REL;
      svcReq  <= 1'b0;
      wrValid <= 1'b0;
      rdLoad  <= 1'b0;
      isAddr  <= 1'b0;
      rwReg   <= 1'b0;
      ackNext <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      wrValid <= 1'b0;
      rdLoad  <= 1'b0;
      if (ev.startDet || ev.stopDet) begin
        state   <= ev.startDet ? ST_ADDR : ST_IDLE;
        sclLow  <= 1'b0;
        sdaMode <= SDA_REL;
        svcReq  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (ev.sclFall && byteDone) begin
            if (addrMatch) begin
              state   <= ST_HOLD;
              sclLow  <= 1'b1;
              svcReq  <= 1'b1;
              isAddr  <= 1'b1;
              rwReg   <= rwBit;
              ackNext <= 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_WRITE: if (ev.sclFall && byteDone) begin
            state   <= ST_HOLD;
            sclLow  <= 1'b1;
            svcReq  <= 1'b1;
            isAddr  <= 1'b0;
            ackNext <= ~bufFull;
            wrValid <= ~bufFull;
          end
          ST_HOLD: if (svcDone) begin
            sclLow <= 1'b0;
            svcReq <= 1'b0;
            rdLoad <= rwReg;
            if (rwReg && !isAddr) begin
              state   <= ST_READ;
              sdaMode <= SDA_DATA;
            end else begin
              state   <= ST_ACK;
              sdaMode <= ackNext ? SDA_ACK : SDA_REL;
            end
          end
          ST_ACK: if (ev.sclFall) begin
            if (!ackNext) begin
              state   <= ST_SKIP;
              sdaMode <= SDA_REL;
            end else if (rwReg) begin
              state   <= ST_READ;
              sdaMode <= SDA_DATA;
            end else begin
              state   <= ST_WRITE;
              sdaMode <= SDA_REL;
            end
          end
          ST_READ: if (ev.sclFall && byteDone) begin
            state   <= ST_RDACK;
            sdaMode <= SDA_REL;
          end
          ST_RDACK: begin
            if (ev.sclRise) hostAck <= ~ev.sdaBit;
            if (ev.sclFall) begin
              if (hostAck) begin
                state  <= ST_HOLD;
                sclLow <= 1'b1;
                svcReq <= 1'b1;
                isAddr <= 1'b0;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_stretch_target.sv
`timescale 1ns/1ps
module i2c_stretch_target
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic [DATA_W-1:0] wrData,
  output logic              wrValid,
  input  logic              bufFull,
  input  logic [DATA_W-1:0] rdData,
  output logic              rdLoad,
  output logic              svcReq,
  input  logic              svcDone
);
  dpCmd_t   cmd;
  busEv_t   ev;
  sdaMode_e sdaMode;
  logic     byteDone, addrMatch, rwBit, msbOut, sclLow;

  i2c_tgt_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd),
    .rdData(rdData), .ev(ev), .byteDone(byteDone), .shiftByte(wrData),
    .addrMatch(addrMatch), .rwBit(rwBit), .msbOut(msbOut)
  );

  i2c_tgt_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .byteDone(byteDone),
    .addrMatch(addrMatch), .rwBit(rwBit), .bufFull(bufFull),
    .svcDone(svcDone), .cmd(cmd), .sclLow(sclLow), .sdaMode(sdaMode),
    .svcReq(svcReq), .wrValid(wrValid), .rdLoad(rdLoad)
  );

  assign sclDriveLow = sclLow;
  assign sdaDriveLow = (sdaMode == SDA_ACK) || ((sdaMode == SDA_DATA) && !msbOut);
endmodule

// File: rtl/i2c_tgt_chk.sv
`timescale 1ns/1ps
module i2c_tgt_chk (
  input logic clk,
  input logic rstN,
  input logic svcReq,
  input logic svcDone,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic wrValid,
  input logic rdLoad,
  input logic bufFull
);
  p_stretch_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> sclDriveLow);

  p_stretch_until_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (svcReq && !svcDone) |=> svcReq);

  p_sda_free_in_stretch_r7: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> !sdaDriveLow);

  p_release_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(svcReq) |-> !sclDriveLow);

  p_wr_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  p_full_blocks_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> !$past(bufFull));

  p_load_after_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdLoad) |-> $past(svcDone));
endmodule

bind i2c_stretch_target i2c_tgt_chk u_chk (
  .clk(clk), .rstN(rstN), .svcReq(svcReq), .svcDone(svcDone),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .wrValid(wrValid), .rdLoad(rdLoad), .bufFull(bufFull)
);

// File: tb/tb_i2c_stretch_target.sv
`timescale 1ns/1ps
module tb_i2c_stretch_target;
  localparam int HALF = 20;
  localparam int SVC_WAIT = 30;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic bufFull = 1'b0, svcDone = 1'b0;
  logic [7:0] rdData;
  logic sclDriveLow, sdaDriveLow, wrValid, rdLoad, svcReq;
  logic [7:0] wrData;
  logic sclLine, sdaLine;

  int nChecks = 0, nFail = 0;
  int wrCount = 0, rdLoadCnt = 0, rdIdx = 0, svcCount = 0, stretchBad = 0;
  logic [7:0] lastWr = 8'h00;

  always #2.5 clk = ~clk;

  assign sclLine = !(mSclLow || sclDriveLow);
  assign sdaLine = !(mSdaLow || sdaDriveLow);

  i2c_stretch_target #(.OWN_ADDR(OWN)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .wrData(wrData), .wrValid(wrValid), .bufFull(bufFull),
    .rdData(rdData), .rdLoad(rdLoad), .svcReq(svcReq), .svcDone(svcDone)
  );

  function automatic logic [7:0] rdPat(input int i);
    return 8'((i * 53 + 17) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; tick(4);
    mSclLow = 1'b0; waitHigh(); tick(HALF);
    mSdaLow = 1'b1; tick(HALF);
    mSclLow = 1'b1; tick(4);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(HALF);
    mSclLow = 1'b0; waitHigh(); tick(HALF);
    mSdaLow = 1'b0; tick(HALF);
  endtask

  task automatic clockBit(input logic b, output logic s, output logic tgtDrv);
    mSdaLow = !b; tick(HALF);
    mSclLow = 1'b0; waitHigh(); tick(HALF / 2);
    s = sdaLine; tgtDrv = sdaDriveLow;
    tick(HALF / 2);
    mSclLow = 1'b1; tick(4);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s, d;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s, d);
    clockBit(1'b1, s, d);
    ack = !s;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic giveAck, output logic tgtDrv);
    logic s, d;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s, d);
      v[i] = s;
    end
    clockBit(!giveAck, s, tgtDrv);
  endtask

  // local side: captures written bytes and advances read data
  initial begin
    rdData = rdPat(0);
    forever begin
      @(negedge clk);
      if (wrValid) begin wrCount++; lastWr = wrData; end
      if (rdLoad) begin rdLoadCnt++; rdIdx++; rdData = rdPat(rdIdx); end
    end
  end

  // local side: services each request after a delay, watching SCL stay low
  initial begin
    forever begin
      @(negedge clk);
      if (svcReq) begin
        svcCount++;
        repeat (SVC_WAIT) begin
          @(negedge clk);
          if (sclLine) stretchBad++;
        end
        svcDone = 1'b1;
        @(negedge clk);
        svcDone = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    logic ack, drv, s, d;
    logic [7:0] v;
    int expSvc = 0, wrBefore;

    tick(5);
    rstN = 1'b1;
    tick(2);
    // R8 reset state
    chk("R8 reset lines released", !sclDriveLow && !sdaDriveLow && !svcReq && !wrValid && !rdLoad,
        {sclDriveLow, sdaDriveLow, svcReq, wrValid, rdLoad}, 0);

    // R1 R10: every address with the write bit
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      chk("R1 address ack", ack == (7'(a) == OWN), int'(ack), int'(7'(a) == OWN));
      if (7'(a) == OWN) expSvc++;
      if ((a % 16) == 3) begin
        wrBefore = wrCount;
        sendByte(8'hC3, ack);
        chk("R1 foreign target silent", !ack && wrCount == wrBefore, wrCount - wrBefore, 0);
      end
      busStop();
    end

    // R2 R3 R7 write sweep
    busStart();
    sendByte({OWN, 1'b0}, ack);
    expSvc++;
    chk("R10 write address ack", ack, int'(ack), 1);
    for (int k = 0; k < 16; k++) begin
      v = (k < 8) ? 8'(1 << k) : 8'((k * 37 + 11) & 8'hFF);
      wrBefore = wrCount;
      sendByte(v, ack);
      expSvc++;
      chk("R3 written byte acked", ack, int'(ack), 1);
      chk("R2 written byte value", wrCount == wrBefore + 1 && lastWr == v, int'(lastWr), int'(v));
      chk("R7 SCL released after service", !sclDriveLow, int'(sclDriveLow), 0);
    end
    // R6 buffer full
    bufFull = 1'b1;
    wrBefore = wrCount;
    sendByte(8'h77, ack);
    expSvc++;
    chk("R6 full byte nacked", !ack, int'(ack), 0);
    chk("R6 full byte not delivered", wrCount == wrBefore, wrCount - wrBefore, 0);
    bufFull = 1'b0;
    busStop();

    // R4 R5 R10 read
    busStart();
    sendByte({OWN, 1'b1}, ack);
    expSvc++;
    chk("R10 read address ack", ack, int'(ack), 1);
    for (int j = 0; j < 6; j++) begin
      recvByte(v, j < 5, drv);
      if (j < 5) expSvc++;
      chk("R4 read byte value", v == rdPat(j), int'(v), int'(rdPat(j)));
      chk("R4 SDA released in ack clock", !drv, int'(drv), 0);
    end
    v = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s, d);
      v[i] = s;
    end
    chk("R5 no data after nack", v == 8'hFF, int'(v), 8'hFF);
    chk("R5 loads stop after nack", rdLoadCnt == 6, rdLoadCnt, 6);
    busStop();

    // R9 repeated START in mid byte
    busStart();
    sendByte({OWN, 1'b0}, ack);
    expSvc++;
    wrBefore = wrCount;
    for (int i = 0; i < 4; i++) clockBit(1'b1, s, d);
    busStart();
    sendByte({OWN, 1'b1}, ack);
    expSvc++;
    chk("R9 restart address ack", ack, int'(ack), 1);
    recvByte(v, 1'b0, drv);
    chk("R9 read after restart", v == rdPat(6), int'(v), int'(rdPat(6)));
    chk("R9 aborted byte dropped", wrCount == wrBefore, wrCount - wrBefore, 0);
    busStop();

    // R8 STOP in mid byte, then clocks without START
    busStart();
    sendByte({OWN, 1'b0}, ack);
    expSvc++;
    for (int i = 0; i < 2; i++) clockBit(1'b0, s, d);
    busStop();
    tick(4);
    chk("R8 lines released after stop", !sclDriveLow && !sdaDriveLow && !svcReq,
        {sclDriveLow, sdaDriveLow, svcReq}, 0);
    wrBefore = wrCount;
    mSclLow = 1'b1; tick(4);
    sendByte({OWN, 1'b0}, ack);
    chk("R8 no ack without start", !ack, int'(ack), 0);
    sendByte(8'hA5, ack);
    chk("R8 no byte without start", !ack && wrCount == wrBefore, wrCount - wrBefore, 0);
    busStop();
    tick(SVC_WAIT + 10);

    chk("R7 stretch held on the line", stretchBad == 0, stretchBad, 0);
    chk("R7 service count", svcCount == expSvc, svcCount, expSvc);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule